// File: doc/BRIEF.md
# Compression-Based Inline ECC Layout Engine

This engine sits between a last-level cache and a 64-bit memory channel that has no spare devices for check bits. The memory holds whole 64-byte lines. On a write the engine tries to pack the line with a base-plus-delta scheme. Word 0 is the base, and every word is stored as a signed 8-bit difference from it. If every difference fits, the 128-bit packed form and a 64-bit check value share one 512-bit memory block, and a single access serves the line. If any difference does not fit, the line is stored uncompressed in its home block. The three bits that cannot fit there, together with the check value, go to an overflow block whose address is the line index plus a programmable overflow-region base.

A three-bit layout code at the top of every home block tells reads which layout applies. The code is triple-replicated and decoded by majority, so it is protected apart from the data check. On a read the engine fetches the home block and decodes the layout code. For an uncompressed line it also fetches the overflow block. It then rebuilds the line and reports a mismatch between the recomputed and stored check value as an uncorrectable error. The check value is a stand-in code: four 16-bit CRCs (polynomial 0x1021, seed 0xFFFF). CRC lane k covers the bits whose index modulo 4 equals k.

Top module: `inline_ecc_layout`

## Requirements
- R1: In reset and after it, the engine accepts requests (req_ready=1) and drives no memory request and no response.
- R2: In a line, word i is data[64i+63:64i]. The line packs when (word_i - word_0) taken modulo 2^64 lies in -128..127 for every i. A packed line is written as exactly one block at the line address, with bits [511:509]=111, bits [63:0]=word 0, byte i of bits [127:64] equal to the low byte of (word_i - word_0), and the check value in [191:128].
- R3: A line that does not pack produces two writes. The first goes to the line address, with bits [511:509]=000 and bits [508:0]=data[508:0]. The second goes to ovf_base+address, with bits [66:64]=data[511:509] and the check value in [63:0].
- R4: A write is acknowledged (rsp_valid with rsp_write=1) only after all of its blocks have been accepted by the memory, and the acknowledgement lasts one cycle.
- R5: Reading a packed line issues one memory read and returns the line bit-exact with rsp_uerr=0.
- R6: Reading an unpacked line issues a read of the home block and then a read of ovf_base+address, and returns the line bit-exact with rsp_uerr=0.
- R7: The layout code is decoded by majority, so a single flipped bit among [511:509] still selects the correct layout and returns the exact line.
- R8: A single flipped data bit in a stored home block or overflow block makes the read report rsp_uerr=1.
- R9: A memory request holds its valid, address, direction and write data steady until mem_ready accepts it.
- R10: The pack boundary is exact: differences of +127 and -128 pack, while +128 and -129 do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_base | input | ADDR_W | Base line index of the overflow region |
| req_valid | input | 1 | Cache request valid |
| req_ready | output | 1 | Engine can take a request |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_addr | input | ADDR_W | Line index |
| req_data | input | 512 | Line to write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_data | output | 512 | Line returned by a read |
| rsp_uerr | output | 1 | Check mismatch on a read |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory block index |
| mem_wdata | output | 512 | Block to write |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 512 | Block read from memory |

## Verification
A wrong pack decision or field placement shows at the memory port within the same request: the block count, the layout code or the overflow address differ from what the line's differences predict. A wrong layout decode or reassembly shows as soon as the line is read back. The engine then issues the wrong number of reads, returns corrupted data, or raises rsp_uerr on a clean line. Flag and data corruption injected into the memory model separates majority decoding from the data check within one read.

// File: rtl/inline_ecc_layout.sv
module inline_ecc_layout #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ovf_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [511:0]      req_data,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [511:0]      rsp_data,
  output logic              rsp_uerr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [511:0]      mem_wdata,
  input  logic              mem_rvalid,
  input  logic [511:0]      mem_rdata
);
  localparam int LINE_W  = 512;
  localparam int WW      = 64;
  localparam int WORDS   = LINE_W / WW;
  localparam int DW      = 8;
  localparam int CW      = 64;
  localparam int FLAG_LO = LINE_W - 3;
  localparam int COMP_W  = WW + WORDS * DW;
  localparam int PAD_W   = FLAG_LO - COMP_W - CW;
  localparam bit ROOM    = PAD_W >= 0;

  typedef enum logic [2:0] {
    S_IDLE, S_WMAIN, S_WOVF, S_RMAIN, S_RWAIT, S_ROVF, S_ROWAIT, S_RSP
  } state_t;

  state_t            state;
  logic              op_wr;
  logic [ADDR_W-1:0] addr;
  logic [LINE_W-1:0] line;
  logic [LINE_W-1:0] blk;
  logic [CW+2:0]     ovf;

  function automatic logic [CW-1:0] crc4x16(input logic [LINE_W-1:0] v);
    logic [3:0][15:0] c;
    logic fb;
    c = {4{16'hFFFF}};
    for (int i = 0; i < LINE_W; i++) begin
      fb = c[i % 4][15] ^ v[i];
      c[i % 4] = {c[i % 4][14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  function automatic logic maj3(input logic [2:0] f);
    return (f[0] & f[1]) | (f[0] & f[2]) | (f[1] & f[2]);
  endfunction

  // pack test and packed form
  logic [WORDS*DW-1:0] deltas;
  logic [WW-1:0]       diff;
  logic                fits, packed_ok;
  logic [COMP_W-1:0]   comp;

  always_comb begin
    fits = 1'b1;
    diff = '0;
    deltas = '0;
    for (int i = 0; i < WORDS; i++) begin
      diff = line[i*WW +: WW] - line[WW-1:0];
      deltas[i*DW +: DW] = diff[DW-1:0];
      if (diff != {{(WW-DW){diff[DW-1]}}, diff[DW-1:0]}) fits = 1'b0;
    end
  end

  assign packed_ok = fits && ROOM;
  assign comp      = {deltas, line[WW-1:0]};

  // read side reassembly
  logic              rflag;
  logic [COMP_W-1:0] rd_comp;
  logic [LINE_W-1:0] rd_unpk, rd_raw, rd_line;
  logic [CW-1:0]     rd_stored, chk;

  assign rflag   = maj3(blk[LINE_W-1:FLAG_LO]);
  assign rd_comp = blk[COMP_W-1:0];
  assign rd_raw  = {ovf[CW+2:CW], blk[FLAG_LO-1:0]};

  always_comb begin
    for (int i = 0; i < WORDS; i++)
      rd_unpk[i*WW +: WW] = rd_comp[WW-1:0]
        + {{(WW-DW){rd_comp[WW+i*DW+DW-1]}}, rd_comp[WW+i*DW +: DW]};
  end

  assign rd_line   = rflag ? rd_unpk : rd_raw;
  assign rd_stored = rflag ? blk[COMP_W +: CW] : ovf[CW-1:0];
  assign chk = crc4x16(op_wr ? (packed_ok ? LINE_W'(comp) : line)
                             : (rflag ? LINE_W'(rd_comp) : rd_raw));

  // memory side
  logic [LINE_W-1:0] main_blk, ovf_blk;
  logic              at_ovf;

  assign main_blk = packed_ok ? {3'b111, {(PAD_W){1'b0}}, chk, comp}
                              : {3'b000, line[FLAG_LO-1:0]};
  assign ovf_blk  = {{(LINE_W-CW-3){1'b0}}, line[LINE_W-1:FLAG_LO], chk};
  assign at_ovf   = (state == S_WOVF) || (state == S_ROVF);

  assign req_ready = state == S_IDLE;
  assign mem_write = (state == S_WMAIN) || at_ovf && op_wr;
  assign mem_valid = mem_write || (state == S_RMAIN) || (state == S_ROVF);
  assign mem_addr  = at_ovf ? ovf_base + addr : addr;
  assign mem_wdata = !mem_write ? '0 : (state == S_WOVF) ? ovf_blk : main_blk;

  assign rsp_valid = state == S_RSP;
  assign rsp_write = op_wr;
  assign rsp_data  = op_wr ? '0 : rd_line;
  assign rsp_uerr  = !op_wr && (chk != rd_stored);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_wr <= 1'b0;
      addr  <= '0;
      line  <= '0;
      blk   <= '0;
      ovf   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_wr <= req_write;
          addr  <= req_addr;
          if (req_write) line <= req_data;
          state <= req_write ? S_WMAIN : S_RMAIN;
        end
        S_WMAIN:  if (mem_ready) state <= packed_ok ? S_RSP : S_WOVF;
        S_WOVF:   if (mem_ready) state <= S_RSP;
        S_RMAIN:  if (mem_ready) state <= S_RWAIT;
        S_RWAIT:  if (mem_rvalid) begin
          blk   <= mem_rdata;
          state <= maj3(mem_rdata[LINE_W-1:FLAG_LO]) ? S_RSP : S_ROVF;
        end
        S_ROVF:   if (mem_ready) state <= S_ROWAIT;
        S_ROWAIT: if (mem_rvalid) begin
          ovf   <= mem_rdata[CW+2:0];
          state <= S_RSP;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

module inline_ecc_layout_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [511:0]      mem_wdata
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !rsp_valid);

  // R2 / R3: home blocks carry 111 or 000, overflow blocks carry 000
  assert_flag_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |->
      (mem_wdata[511:509] == 3'b111) || (mem_wdata[511:509] == 3'b000));

  assert_ack_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_valid);

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
      && $stable(mem_write) && $stable(mem_wdata));
endmodule

bind inline_ecc_layout inline_ecc_layout_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/inline_ecc_layout_tb.sv
module inline_ecc_layout_tb;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam logic [AW-1:0] OVF = 8'h80;
  localparam int NV = 10;
  // base, stride, expected to pack
  localparam logic [128:0] VEC [NV] = '{
    {64'h0123_4567_89AB_CDEF, 64'd0,                   1'b1},
    {64'h0000_0000_0000_1000, 64'd1,                   1'b1},
    {64'h4000_0000_0000_0000, 64'd18,                  1'b1},
    {64'h4000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFEE, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFF0, 64'd5,                   1'b1},
    {64'h1111_2222_3333_4444, 64'd19,                  1'b0},
    {64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FFED, 1'b0},
    {64'h0000_0000_0000_0000, 64'h0000_0001_0000_0000, 1'b0},
    {64'hDEAD_BEEF_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
    {64'h7FFF_FFFF_FFFF_FFFF, 64'd3,                   1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [511:0] req_data = '0;
  logic req_ready, rsp_valid, rsp_write, rsp_uerr;
  logic [511:0] rsp_data;
  logic mem_valid, mem_ready, mem_write;
  logic [AW-1:0] mem_addr;
  logic [511:0] mem_wdata;
  logic mem_rvalid = 0;
  logic [511:0] mem_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  inline_ecc_layout #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ovf_base(OVF),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_data(rsp_data), .rsp_uerr(rsp_uerr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  // memory model with back-pressure and bit-flip injection
  logic [511:0] mem [256];
  logic [15:0] lf = 16'hACE1;
  int wcnt = 0, rcnt = 0;
  logic [AW-1:0] wa [256];
  logic [511:0]  wd [256];
  logic [AW-1:0] ra [256];
  logic flip_req = 0;
  logic [AW-1:0] flip_a = '0;
  int flip_b = 0;

  assign mem_ready = lf[0] | lf[1];

  always @(posedge clk) begin
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    mem_rvalid <= 1'b0;
    if (flip_req) mem[flip_a][flip_b] <= ~mem[flip_a][flip_b];
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        mem[mem_addr] <= mem_wdata;
        wa[wcnt % 256] <= mem_addr;
        wd[wcnt % 256] <= mem_wdata;
        wcnt <= wcnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr];
        ra[rcnt % 256] <= mem_addr;
        rcnt <= rcnt + 1;
      end
    end
  end

  int n_tests = 0, n_fail = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] mk(input logic [63:0] b, input logic [63:0] s);
    logic [511:0] r;
    for (int i = 0; i < 8; i++) r[i*64 +: 64] = b + 64'(i) * s;
    return r;
  endfunction

  task automatic wait_rsp(output bit ok);
    int n = 0;
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    ok = rsp_valid;
    if (!ok) check(1'b0, "watchdog", 512'(n), 512'(0));
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [511:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [511:0] d, input bit pk, input string tag);
    int w0;
    bit ok;
    logic [63:0] df;
    w0 = wcnt;
    issue(1'b1, a, d);
    wait_rsp(ok);
    if (!ok) return;
    check(rsp_write && (wcnt - w0) == (pk ? 1 : 2), "R4 ack after all blocks", 512'(wcnt - w0), 512'(pk ? 1 : 2));
    if (pk) begin
      check(wa[w0 % 256] == a && wd[w0 % 256][511:509] == 3'b111 && wd[w0 % 256][63:0] == d[63:0],
            {"R2 packed block ", tag}, wd[w0 % 256], 512'(a));
      for (int i = 0; i < 8; i++) begin
        df = d[i*64 +: 64] - d[63:0];
        check(wd[w0 % 256][64 + i*8 +: 8] == df[7:0], {"R2 delta byte ", tag},
              512'(wd[w0 % 256][64 + i*8 +: 8]), 512'(df[7:0]));
      end
    end else begin
      check(wa[w0 % 256] == a && wd[w0 % 256][511:509] == 3'b000 && wd[w0 % 256][508:0] == d[508:0],
            {"R3 home block ", tag}, wd[w0 % 256], d);
      check(wa[(w0 + 1) % 256] == AW'(OVF + a) && wd[(w0 + 1) % 256][66:64] == d[511:509],
            {"R3 overflow block ", tag}, 512'(wa[(w0 + 1) % 256]), 512'(OVF + a));
    end
    @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [511:0] d, input bit pk,
                         input bit exp_err, input string tag);
    int r0;
    bit ok;
    r0 = rcnt;
    issue(1'b0, a, '0);
    wait_rsp(ok);
    if (!ok) return;
    check((rcnt - r0) == (pk ? 1 : 2) && ra[r0 % 256] == a, {"R5/R6 read count ", tag},
          512'(rcnt - r0), 512'(pk ? 1 : 2));
    if (!pk) check(ra[(r0 + 1) % 256] == AW'(OVF + a), {"R6 overflow read ", tag},
                   512'(ra[(r0 + 1) % 256]), 512'(OVF + a));
    check(rsp_uerr == exp_err, {"uerr ", tag}, 512'(rsp_uerr), 512'(exp_err));
    if (!exp_err) check(!rsp_write && rsp_data == d, {"data ", tag}, rsp_data, d);
    @(negedge clk);
  endtask

  task automatic flip(input logic [AW-1:0] a, input int b);
    flip_a = a; flip_b = b; flip_req = 1;
    @(negedge clk);
    flip_req = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [511:0] ln;
    logic [63:0] x;
    repeat (3) @(negedge clk);
    check(req_ready && !mem_valid && !rsp_valid, "R1 in reset", 512'({req_ready, mem_valid, rsp_valid}), 512'(3'b100));
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !mem_valid && !rsp_valid, "R1 after reset", 512'({req_ready, mem_valid, rsp_valid}), 512'(3'b100));

    // vector table: write then read back; R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++)
      do_write(AW'(v), mk(VEC[v][128:65], VEC[v][64:1]), VEC[v][0], $sformatf("vec%0d", v));
    for (int v = 0; v < NV; v++)
      do_read(AW'(v), mk(VEC[v][128:65], VEC[v][64:1]), VEC[v][0], 1'b0, $sformatf("R5 R6 vec%0d", v));

    // R10 boundaries
    x = 64'h5555_0000_0000_0080;
    ln = mk(x, 0); ln[3*64 +: 64] = x + 64'd127; ln[5*64 +: 64] = x - 64'd128;
    do_write(8'd20, ln, 1'b1, "R10 +127/-128");
    do_read(8'd20, ln, 1'b1, 1'b0, "R10 +127/-128");
    ln = mk(x, 0); ln[2*64 +: 64] = x + 64'd128;
    do_write(8'd21, ln, 1'b0, "R10 +128");
    do_read(8'd21, ln, 1'b0, 1'b0, "R10 +128");
    ln = mk(x, 0); ln[6*64 +: 64] = x - 64'd129;
    do_write(8'd22, ln, 1'b0, "R10 -129");
    do_read(8'd22, ln, 1'b0, 1'b0, "R10 -129");

    // R7 one flipped layout bit
    flip(8'd0, 510);
    do_read(8'd0, mk(VEC[0][128:65], VEC[0][64:1]), 1'b1, 1'b0, "R7 packed flag flip");
    flip(8'd5, 511);
    do_read(8'd5, mk(VEC[5][128:65], VEC[5][64:1]), 1'b0, 1'b0, "R7 raw flag flip");

    // R8 data corruption
    flip(8'd1, 70);
    do_read(8'd1, '0, 1'b1, 1'b1, "R8 packed delta bit");
    flip(8'd7, 300);
    do_read(8'd7, '0, 1'b0, 1'b1, "R8 raw home bit");
    flip(AW'(OVF + 6), 65);
    do_read(8'd6, '0, 1'b0, 1'b1, "R8 overflow bit");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule